// File: doc/BRIEF.md
# Qualified I/O Port Decoder

This block turns the I/O bus cycles of an 8-bit processor into individual active-low port strobes. Each bus cycle is first classified from the I/O request, read, write and opcode-fetch/interrupt-acknowledge lines. Only a genuine I/O read or I/O write may select a port; an interrupt acknowledge, an idle bus and the illegal case of read and write asserted together all select nothing.

A first stage cuts the lower part of the 8-bit I/O space into eight groups of eight ports, one active-low group select each, using address bits 5:3 while bits 7:6 must be zero. A second stage, used for writes only, splits the group at 0x38-0x3F into eight single-address write strobes decoded from address bits 2:0; strobe 0 keeps the existing port at 0x38 and one of the others serves as the memory mapper's control register. The bus inputs are sampled on every clock edge and the strobes are registered, so each strobe is free of decode glitches and follows the bus one cycle later.

Top module: `iodec_top`

## Requirements
- R1: While rst_n is low every group select and every write strobe is high (inactive), whatever the bus inputs do.
- R2: An I/O read (iorq_n=0, rd_n=0, wr_n=1, m1_n=1) with addr[7:6]=0 drives grp_sel_n[addr[5:3]] low on the clock edge after the inputs are sampled, all other group selects high and all write strobes high.
- R3: An I/O write (iorq_n=0, wr_n=0, rd_n=1, m1_n=1) with addr[7:6]=0 drives grp_sel_n[addr[5:3]] low one cycle later.
- R4: When iorq_n=0 and m1_n=0 (interrupt acknowledge) no group select and no write strobe goes low, regardless of rd_n and wr_n.
- R5: With iorq_n=1 every output is high one cycle later.
- R6: An I/O cycle with addr[7:6] not zero selects no group and no write strobe.
- R7: A cycle with rd_n and wr_n both low selects nothing.
- R8: At most one group select and at most one write strobe are low in any cycle.
- R9: An I/O write to address 0x38+k (k=0..7) drives wport_n[k] low together with grp_sel_n[7] one cycle later; a write strobe is never low during a read or outside group 7.
- R10: Every output returns high on the cycle after the qualifying bus cycle ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode fetch / interrupt acknowledge marker, active low |
| addr | input | 8 | Low byte of the I/O address |
| grp_sel_n | output | 8 | Active-low select for each 8-port group (bit i covers 8*i..8*i+7) |
| wport_n | output | 8 | Active-low write strobes for ports 0x38..0x3F (bit k is 0x38+k) |

## Verification
Every strobe is due exactly one clock edge after the bus inputs are presented: the bench applies inputs just after a falling edge, waits for the next rising edge where the output registers load, and compares one nanosecond later, before any further input change. Expected strobes are recomputed from the presented inputs alone, so a check after a cycle ends also proves the strobe was released (R10) without sampling twice.

// File: rtl/iodec_pkg.sv
package iodec_pkg;

  // Classification of one sampled bus state
  typedef enum logic [1:0] {
    CYC_IDLE   = 2'd0,
    CYC_READ   = 2'd1,
    CYC_WRITE  = 2'd2,
    CYC_INTACK = 2'd3
  } cyc_e;

endpackage

// File: rtl/iodec_qualify.sv
module iodec_qualify
  import iodec_pkg::*;
(
  input  logic iorq_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic m1_n,
  output cyc_e cyc
);

  // Interrupt acknowledge wins over any read/write level; a bus with both
  // strobes low is treated as idle so that it can never select a port.
  always_comb begin
    if (iorq_n) begin
      cyc = CYC_IDLE;
    end else if (!m1_n) begin
      cyc = CYC_INTACK;
    end else if (!rd_n && wr_n) begin
      cyc = CYC_READ;
    end else if (!wr_n && rd_n) begin
      cyc = CYC_WRITE;
    end else begin
      cyc = CYC_IDLE;
    end
  end

endmodule

// File: rtl/iodec_onehot.sv
module iodec_onehot #(
  parameter int SEL_W = 3
) (
  input  logic                  en,
  input  logic [SEL_W-1:0]      sel,
  output logic [(1<<SEL_W)-1:0] hot
);

  localparam int N_OUT = 1 << SEL_W;

  for (genvar gi = 0; gi < N_OUT; gi++) begin : g_out
    assign hot[gi] = en && (sel == SEL_W'(gi));
  end

endmodule

// File: rtl/iodec_top.sv
module iodec_top
  import iodec_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int GRP_LSB  = 3,
  parameter int GRP_BITS = 3,
  parameter int SUB_GRP  = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         iorq_n,
  input  logic                         rd_n,
  input  logic                         wr_n,
  input  logic                         m1_n,
  input  logic [ADDR_W-1:0]            addr,
  output logic [(1<<GRP_BITS)-1:0]     grp_sel_n,
  output logic [(1<<GRP_LSB)-1:0]      wport_n
);

  localparam int NGRP    = 1 << GRP_BITS;
  localparam int NSUB    = 1 << GRP_LSB;
  localparam int HI_LSB  = GRP_LSB + GRP_BITS;
  localparam int HI_BITS = ADDR_W - HI_LSB;

  cyc_e             cyc;
  logic             hi_ok;
  logic             grp_en;
  logic             sub_en;
  logic [NGRP-1:0]  grp_hot;
  logic [NSUB-1:0]  sub_hot;
  logic [NGRP-1:0]  grp_nxt;
  logic [NSUB-1:0]  wp_nxt;
  logic             upd_en;

  iodec_qualify u_qual (
    .iorq_n (iorq_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .m1_n   (m1_n),
    .cyc    (cyc)
  );

  // Upper address bits must be zero for any group to respond
  if (HI_BITS > 0) begin : g_hi
    assign hi_ok = (addr[ADDR_W-1:HI_LSB] == '0);
  end else begin : g_nohi
    assign hi_ok = 1'b1;
  end

  assign grp_en = hi_ok && ((cyc == CYC_READ) || (cyc == CYC_WRITE));

  iodec_onehot #(.SEL_W(GRP_BITS)) u_grp (
    .en  (grp_en),
    .sel (addr[HI_LSB-1:GRP_LSB]),
    .hot (grp_hot)
  );

  // Second stage: write-only, chained behind the first-stage group output
  assign sub_en = grp_hot[SUB_GRP] && (cyc == CYC_WRITE);

  iodec_onehot #(.SEL_W(GRP_LSB)) u_sub (
    .en  (sub_en),
    .sel (addr[GRP_LSB-1:0]),
    .hot (sub_hot)
  );

  // Next state
  always_comb begin
    grp_nxt = ~grp_hot;
    wp_nxt  = ~sub_hot;
    upd_en  = (grp_nxt != grp_sel_n) || (wp_nxt != wport_n);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_sel_n <= '1;
      wport_n   <= '1;
    end else if (upd_en) begin
      grp_sel_n <= grp_nxt;
      wport_n   <= wp_nxt;
    end
  end

  // R8: one-hot outputs
  a_r8_grp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~grp_sel_n));
  a_r8_wport_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~wport_n));

  // R9: a write strobe only rides on the sub-decoded group
  a_r9_wport_in_grp: assert property (@(posedge clk) disable iff (!rst_n)
    !(&wport_n) |-> !grp_sel_n[SUB_GRP]);
  a_r9_read_no_wport: assert property (@(posedge clk) disable iff (!rst_n)
    (!iorq_n && !rd_n && m1_n) |=> (&wport_n));

  // R4: interrupt acknowledge selects nothing
  a_r4_intack_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!iorq_n && !m1_n) |=> ((&grp_sel_n) && (&wport_n)));

  // R5: idle bus selects nothing
  a_r5_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    iorq_n |=> ((&grp_sel_n) && (&wport_n)));

  // R7: contradictory strobes select nothing
  a_r7_both_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !wr_n) |=> ((&grp_sel_n) && (&wport_n)));

  // R2: a qualified read in range always hits a group
  a_r2_read_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (!iorq_n && !rd_n && wr_n && m1_n && hi_ok) |=> !(&grp_sel_n));

endmodule

// File: tb/iodec_top_tb.sv
module iodec_top_tb;

  logic       clk;
  logic       rst_n;
  logic       iorq_n, rd_n, wr_n, m1_n;
  logic [7:0] addr;
  logic [7:0] grp_sel_n;
  logic [7:0] wport_n;

  int n_chk;
  int n_bad;
  bit done;

  iodec_top u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .iorq_n    (iorq_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .m1_n      (m1_n),
    .addr      (addr),
    .grp_sel_n (grp_sel_n),
    .wport_n   (wport_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic cyc_ok(logic q, logic r, logic w, logic m);
    return !q && m && (r != w);
  endfunction

  function automatic logic [7:0] exp_grp(logic q, logic r, logic w, logic m, logic [7:0] a);
    logic [7:0] v;
    v = 8'hFF;
    if (cyc_ok(q, r, w, m) && a[7:6] == 2'b00) v[a[5:3]] = 1'b0;
    return v;
  endfunction

  function automatic logic [7:0] exp_wp(logic q, logic r, logic w, logic m, logic [7:0] a);
    logic [7:0] v;
    v = 8'hFF;
    if (cyc_ok(q, r, w, m) && !w && a[7:3] == 5'b00111) v[a[2:0]] = 1'b0;
    return v;
  endfunction

  task automatic check(string tag, logic [7:0] eg, logic [7:0] ew);
    n_chk++;
    if (grp_sel_n !== eg || wport_n !== ew) begin
      n_bad++;
      $display("FAIL %s: grp_sel_n=%b exp=%b wport_n=%b exp=%b",
               tag, grp_sel_n, eg, wport_n, ew);
    end
  endtask

  task automatic step(string tag, logic q, logic r, logic w, logic m, logic [7:0] a);
    @(negedge clk);
    iorq_n = q; rd_n = r; wr_n = w; m1_n = m; addr = a;
    @(posedge clk);
    #1;
    check(tag, exp_grp(q, r, w, m, a), exp_wp(q, r, w, m, a));
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    n_chk = 0;
    n_bad = 0;
    done  = 0;
    seed  = 32'h1234_5678;
    void'($urandom(seed));
    rst_n = 1'b0;
    iorq_n = 1'b0; rd_n = 1'b1; wr_n = 1'b0; m1_n = 1'b1; addr = 8'h38;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset with active write", 8'hFF, 8'hFF);
    @(negedge clk);
    iorq_n = 1'b1; wr_n = 1'b1;
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 after release idle", 8'hFF, 8'hFF);

    // Directed corner cases
    step("R2 read 0x00",         0, 0, 1, 1, 8'h00);
    step("R2 read 0x3A",         0, 0, 1, 1, 8'h3A);
    step("R10 release",          1, 1, 1, 1, 8'h3A);
    step("R3 write 0x10",        0, 1, 0, 1, 8'h10);
    step("R9 write 0x38 port0",  0, 1, 0, 1, 8'h38);
    step("R9 write 0x3F port7",  0, 1, 0, 1, 8'h3F);
    step("R10 release write",    1, 1, 1, 1, 8'h3F);
    step("R4 intack with read",  0, 0, 1, 0, 8'h38);
    step("R4 intack with write", 0, 1, 0, 0, 8'h3C);
    step("R7 both strobes",      0, 0, 0, 1, 8'h39);
    step("R6 high addr 0x78",    0, 1, 0, 1, 8'h78);
    step("R6 high addr 0xBB",    0, 0, 1, 1, 8'hBB);
    step("R5 idle with strobes", 1, 0, 0, 1, 8'h38);
    step("R3 write 0x2F",        0, 1, 0, 1, 8'h2F);

    // Random mix, biased toward the low address range and active cycles
    for (int i = 0; i < 2000; i++) begin
      logic q, r, w, m;
      logic [7:0] a;
      logic [7:0] eg, ew;
      string tag;
      q = ($urandom % 5) == 0;
      r = $urandom % 2;
      w = ($urandom % 4) == 0 ? r : !r;
      m = ($urandom % 6) != 0;
      a = $urandom;
      if ($urandom % 4 != 0) a[7:6] = 2'b00;
      if ($urandom % 3 == 0) a[5:3] = 3'b111;
      eg = exp_grp(q, r, w, m, a);
      ew = exp_wp(q, r, w, m, a);
      if (q)                       tag = "R5 random idle";
      else if (!m)                 tag = "R4 random intack";
      else if (!r && !w)           tag = "R7 random both";
      else if (a[7:6] != 2'b00)    tag = "R6 random high";
      else if (!r)                 tag = "R2 random read";
      else if (ew != 8'hFF)        tag = "R9 random port write";
      else                         tag = "R3 random write";
      step(tag, q, r, w, m, a);
      if (($countones(~grp_sel_n) > 1) || ($countones(~wport_n) > 1)) begin
        n_chk++;
        n_bad++;
        $display("FAIL R8: grp_sel_n=%b wport_n=%b exp=at most one low", grp_sel_n, wport_n);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule